// File: doc/BRIEF.md
# UART Receive Character Queue

This block holds the characters a UART receiver has assembled until software reads them through the data register. Every slot stores one data byte together with four status bits (framing error, parity error, line break, overrun) supplied by the deserializer. The queue runs either as a 16-slot first-in first-out buffer or, with FIFO mode off, as a single holding slot. The mode can change at run time, and any change of mode discards the stored characters.

The deserializer offers characters on a push strobe. It may also report a line break, which the queue stores as a zero byte with the break bit set. A read strobe from the data-register path removes the oldest character. The status bits of that character are copied into a separate receive-status word, which stays until the next read or until software writes the clear strobe. The block produces empty and full flags, a fill level, a ready-to-accept output, and a receive interrupt request. The request rises when a push brings the fill level up to the trigger level and falls when a read brings it back down through that level.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the fill level is 0, empty is 1, full is 0, the interrupt request is 0, the status word is 0, and the queue is in single-slot mode.
- R2: In FIFO mode the queue holds 16 characters, returned oldest first. Full is 1 and accept is 0 exactly when 16 are stored.
- R3: A push while the queue is full is dropped. The level, the flags and the stored characters are unchanged.
- R4: In single-slot mode the queue is full after one character and a second push is dropped.
- R5: The interrupt request is set by a push that brings the level to the trigger level (1). It stays set while further characters arrive.
- R6: A read that leaves the level one below the trigger level clears the interrupt request. This includes a read of an empty queue.
- R7: The character output is the oldest stored entry, with bits [11:8] the status bits and [7:0] the data. A read removes it, clears full, and sets empty when the level reaches 0.
- R8: A read copies bits [11:8] of the entry it removes into the status word (bit0 framing, bit1 parity, bit2 break, bit3 overrun). The clear strobe zeroes the status word. When a read and a clear occur in the same cycle, the read wins.
- R9: A break strobe pushes an entry with data 0x00 and status bit 2 set, ORed with the supplied status bits.
- R10: A change of the FIFO-enable input, or a flush strobe, empties the queue: level 0, empty 1, full 0. Pushes and reads in that cycle are ignored, and the interrupt request keeps its value.
- R11: A push and a read in the same cycle apply the read first, so a full queue accepts the new character and its level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push a received character |
| push_data_i | input | 8 | Received data byte |
| push_flags_i | input | 4 | Status bits of the received character |
| brk_i | input | 1 | Push a line-break entry |
| pop_i | input | 1 | Data-register read strobe |
| fifo_en_i | input | 1 | 1 = 16-slot FIFO, 0 = single slot |
| flush_i | input | 1 | Discard all stored characters |
| stat_clr_i | input | 1 | Clear the receive-status word |
| rd_entry_o | output | 12 | Oldest entry {status, data} |
| status_o | output | 4 | Latched status of the last character read |
| level_o | output | 5 | Number of stored characters |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full at the current depth |
| accept_o | output | 1 | Room for another character |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A wrong count or read position shows up at once. The level output and the full and empty flags drift from the reference in the same cycle, and the character presented next is the wrong one. A missed wrap in single-slot mode appears on the read after a mode change. An interrupt request that sets or clears on the wrong crossing is visible on the cycle after the push or read that should have moved it. A status word loaded from the wrong entry appears on the cycle after that read.

// File: rtl/uart_rx_queue_pkg.sv
package uart_rx_queue_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 4;
    localparam int BRK_BIT = 2;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  uart_rx_queue_pkg::rxq_entry_t wr_entry,
    input  logic [PTR_W-1:0]             rd_ptr,
    output uart_rx_queue_pkg::rxq_entry_t rd_entry
);
    import uart_rx_queue_pkg::*;

    rxq_entry_t mem_q [DEPTH];
    rxq_entry_t mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_ptr] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_entry = mem_q[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_any,
    input  logic             pop_i,
    input  logic             fifo_en_i,
    input  logic             flush_i,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             pop_ok,
    output logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic             accept,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [PTR_W-1:0] rpos;
        logic             full;
        logic             empty;
        logic             irq;
        logic             mode;
    } ctrl_st_t;

    localparam ctrl_st_t RST_ST = '{count: '0, rpos: '0, full: 1'b0,
                                    empty: 1'b1, irq: 1'b0, mode: 1'b0};

    ctrl_st_t st_q, st_d;
    logic [CNT_W-1:0] depth_cur;
    logic [PTR_W-1:0] mask;
    logic             do_flush;

    assign depth_cur = st_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign mask      = st_q.mode ? PTR_W'(DEPTH - 1) : '0;
    assign do_flush  = flush_i || (fifo_en_i != st_q.mode);

    always_comb begin
        logic [CNT_W-1:0] c;
        logic [PTR_W-1:0] p;
        logic [CNT_W-1:0] sum;
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_ptr = '0;
        pop_ok = 1'b0;
        c      = st_q.count;
        p      = st_q.rpos;
        sum    = '0;
        if (do_flush) begin
            st_d.count = '0;
            st_d.rpos  = '0;
            st_d.empty = 1'b1;
            st_d.full  = 1'b0;
            st_d.mode  = fifo_en_i;
        end else begin
            if (pop_i) begin
                pop_ok     = 1'b1;
                st_d.full  = 1'b0;
                if (c != '0) begin
                    c = c - CNT_W'(1);
                    p = (p + PTR_W'(1)) & mask;
                end
                if (c == '0) begin
                    st_d.empty = 1'b1;
                end
                if ((c + CNT_W'(1)) == CNT_W'(TRIG)) begin
                    st_d.irq = 1'b0;
                end
            end
            if (push_any && (c < depth_cur)) begin
                sum        = CNT_W'(p) + c;
                wr_en      = 1'b1;
                wr_ptr     = sum[PTR_W-1:0] & mask;
                c          = c + CNT_W'(1);
                st_d.empty = 1'b0;
                if (c == depth_cur) begin
                    st_d.full = 1'b1;
                end
                if (c == CNT_W'(TRIG)) begin
                    st_d.irq = 1'b1;
                end
            end
            st_d.count = c;
            st_d.rpos  = p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr = st_q.rpos;
    assign level  = st_q.count;
    assign empty  = st_q.empty;
    assign full   = st_q.full;
    assign irq    = st_q.irq;
    assign accept = st_q.count < depth_cur;

    // R3: the count never exceeds the active depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= depth_cur);
    // R2: registered full flag agrees with the count
    a_r2_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full == (st_q.count == depth_cur));
    // R7: registered empty flag agrees with the count
    a_r7_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.empty == (st_q.count == '0));
    // R4: single-slot mode never holds more than one entry
    a_r4_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> st_q.count <= CNT_W'(1));
    // R10: a flush leaves the queue empty
    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.count == '0) && st_q.empty && !st_q.full);
    // R6: a lone read at the trigger level drops the request
    a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !do_flush && !push_any && st_q.count == CNT_W'(TRIG)) |=> !st_q.irq);
    // R5: the request only rises at the trigger level
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> st_q.count == CNT_W'(TRIG));
endmodule

// File: rtl/rxq_status.sv
module rxq_status (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   pop_ok,
    input  logic                                   clr_i,
    input  logic [uart_rx_queue_pkg::FLAG_W-1:0]   flags_i,
    output logic [uart_rx_queue_pkg::FLAG_W-1:0]   status_o
);
    import uart_rx_queue_pkg::*;

    logic [FLAG_W-1:0] stat_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (clr_i) begin
            stat_d = '0;
        end
        if (pop_ok) begin
            stat_d = flags_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status_o = stat_q;

    // R8: a clear without a read zeroes the word
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !pop_ok) |=> status_o == '0);
    // R8: a read loads the flags of the removed entry
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> status_o == $past(flags_i));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = uart_rx_queue_pkg::DATA_W + uart_rx_queue_pkg::FLAG_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 push_i,
    input  logic [uart_rx_queue_pkg::DATA_W-1:0] push_data_i,
    input  logic [uart_rx_queue_pkg::FLAG_W-1:0] push_flags_i,
    input  logic                                 brk_i,
    input  logic                                 pop_i,
    input  logic                                 fifo_en_i,
    input  logic                                 flush_i,
    input  logic                                 stat_clr_i,
    output logic [ENT_W-1:0]                     rd_entry_o,
    output logic [uart_rx_queue_pkg::FLAG_W-1:0] status_o,
    output logic [CNT_W-1:0]                     level_o,
    output logic                                 empty_o,
    output logic                                 full_o,
    output logic                                 accept_o,
    output logic                                 irq_o
);
    import uart_rx_queue_pkg::*;

    logic             push_any;
    logic             wr_en;
    logic             pop_ok;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    rxq_entry_t       wr_entry;
    rxq_entry_t       rd_entry;

    assign push_any = push_i || brk_i;

    always_comb begin
        wr_entry.flags = push_flags_i;
        wr_entry.data  = push_data_i;
        if (brk_i) begin
            wr_entry.flags[BRK_BIT] = 1'b1;
            wr_entry.data           = '0;
        end
    end

    rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_any  (push_any),
        .pop_i     (pop_i),
        .fifo_en_i (fifo_en_i),
        .flush_i   (flush_i),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .pop_ok    (pop_ok),
        .level     (level_o),
        .empty     (empty_o),
        .full      (full_o),
        .accept    (accept_o),
        .irq       (irq_o)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_entry (wr_entry),
        .rd_ptr   (rd_ptr),
        .rd_entry (rd_entry)
    );

    rxq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_ok   (pop_ok),
        .clr_i    (stat_clr_i),
        .flags_i  (rd_entry.flags),
        .status_o (status_o)
    );

    assign rd_entry_o = rd_entry;

    // R9: a break push never stores a non-zero byte
    a_r9_break_entry: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |-> (wr_entry.data == '0) && wr_entry.flags[BRK_BIT]);
endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, brk_i = 0, pop_i = 0, fifo_en_i = 0, flush_i = 0, stat_clr_i = 0;
    logic [7:0]  push_data_i = '0;
    logic [3:0]  push_flags_i = '0;
    logic [11:0] rd_entry_o;
    logic [3:0]  status_o;
    logic [4:0]  level_o;
    logic        empty_o, full_o, accept_o, irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference
    logic [11:0] m_q[$];
    int          m_depth = 1;
    bit          m_mode = 0;
    bit          m_full = 0, m_empty = 1, m_irq = 0;
    logic [3:0]  m_stat = '0;
    bit          m_stat_known = 1;

    always #10 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .push_flags_i(push_flags_i), .brk_i(brk_i), .pop_i(pop_i),
        .fifo_en_i(fifo_en_i), .flush_i(flush_i), .stat_clr_i(stat_clr_i),
        .rd_entry_o(rd_entry_o), .status_o(status_o), .level_o(level_o),
        .empty_o(empty_o), .full_o(full_o), .accept_o(accept_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic model_step(bit pu, logic [7:0] d, logic [3:0] f, bit br,
                              bit po, bit fe, bit fl, bit sc);
        logic [11:0] e;
        if (sc) begin
            m_stat = '0;
            m_stat_known = 1;
        end
        if (fl || fe != m_mode) begin
            m_q.delete();
            m_empty = 1;
            m_full = 0;
            m_mode = fe;
            m_depth = fe ? 16 : 1;
        end else begin
            if (po) begin
                m_full = 0;
                if (m_q.size() > 0) begin
                    e = m_q.pop_front();
                    m_stat = e[11:8];
                    m_stat_known = 1;
                end else begin
                    m_stat_known = 0;
                end
                if (m_q.size() == 0) m_empty = 1;
                if (m_q.size() + 1 == 1) m_irq = 0;
            end
            if ((pu || br) && m_q.size() < m_depth) begin
                e = br ? {f | 4'b0100, 8'h00} : {f, d};
                m_q.push_back(e);
                m_empty = 0;
                if (m_q.size() == m_depth) m_full = 1;
                if (m_q.size() == 1) m_irq = 1;
            end
        end
    endtask

    task automatic compare();
        chk("R2 level", 32'(level_o), 32'(m_q.size()));
        chk("R2 full", 32'(full_o), 32'(m_full));
        chk("R7 empty", 32'(empty_o), 32'(m_empty));
        chk("R4 accept", 32'(accept_o), 32'(m_q.size() < m_depth));
        chk("R5 irq", 32'(irq_o), 32'(m_irq));
        if (m_q.size() > 0) chk("R7 entry", 32'(rd_entry_o), 32'(m_q[0]));
        if (m_stat_known) chk("R8 status", 32'(status_o), 32'(m_stat));
    endtask

    task automatic step(bit pu, logic [7:0] d, logic [3:0] f, bit br,
                        bit po, bit fe, bit fl, bit sc);
        @(negedge clk);
        push_i = pu; push_data_i = d; push_flags_i = f; brk_i = br;
        pop_i = po; fifo_en_i = fe; flush_i = fl; stat_clr_i = sc;
        @(posedge clk);
        #1;
        model_step(pu, d, f, br, po, fe, fl, sc);
        compare();
    endtask

    bit fe = 0;
    task automatic push(logic [7:0] d, logic [3:0] f); step(1, d, f, 0, 0, fe, 0, 0); endtask
    task automatic pop();                              step(0, 0, 0, 0, 1, fe, 0, 0); endtask
    task automatic idle();                             step(0, 0, 0, 0, 0, fe, 0, 0); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 level", 32'(level_o), 0);
        chk("R1 empty", 32'(empty_o), 1);
        chk("R1 full", 32'(full_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 status", 32'(status_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: single-slot mode
        push(8'hA5, 4'h1);
        chk("R4 full after one", 32'(full_o), 1);
        chk("R5 irq set", 32'(irq_o), 1);
        push(8'h3C, 4'h0);
        chk("R3 drop level", 32'(level_o), 1);
        chk("R3 drop entry", 32'(rd_entry_o), 32'h1A5);
        pop();
        chk("R8 status load", 32'(status_o), 1);
        chk("R6 irq clear", 32'(irq_o), 0);
        chk("R7 empty", 32'(empty_o), 1);
        // R6: read of an empty queue
        pop();
        chk("R6 empty read irq", 32'(irq_o), 0);
        step(0, 0, 0, 0, 0, fe, 0, 1);
        chk("R8 clear", 32'(status_o), 0);

        // R10: mode change flushes, enter FIFO mode
        fe = 1;
        idle();
        chk("R10 mode change level", 32'(level_o), 0);

        // R2: fill to 16
        for (int i = 0; i < 16; i++) begin
            push(8'(i * 17 + 1), 4'(i));
            if (i == 0) chk("R5 irq on first", 32'(irq_o), 1);
            if (i == 5) chk("R5 irq held", 32'(irq_o), 1);
        end
        chk("R2 full", 32'(full_o), 1);
        chk("R2 accept", 32'(accept_o), 0);
        push(8'hEE, 4'hF);
        chk("R3 full drop level", 32'(level_o), 16);
        chk("R3 full drop front", 32'(rd_entry_o), 32'h001);
        // R11: push and read together while full
        step(1, 8'h77, 4'h2, 0, 1, fe, 0, 0);
        chk("R11 level kept", 32'(level_o), 16);
        chk("R11 front advanced", 32'(rd_entry_o), 32'h112);
        for (int i = 0; i < 16; i++) pop();
        chk("R7 drained", 32'(empty_o), 1);
        chk("R6 irq after drain", 32'(irq_o), 0);

        // R9: break entry
        step(0, 8'hFF, 4'h1, 1, 0, fe, 0, 0);
        chk("R9 break entry", 32'(rd_entry_o), 32'h500);
        pop();
        chk("R9 break status", 32'(status_o), 5);
        // R8: read wins over clear
        push(8'h42, 4'h8);
        step(0, 0, 0, 0, 1, fe, 0, 1);
        chk("R8 read beats clear", 32'(status_o), 8);

        // R10: flush keeps irq
        push(8'h10, 0); push(8'h20, 0); push(8'h30, 0);
        step(0, 0, 0, 0, 0, fe, 1, 0);
        chk("R10 flush level", 32'(level_o), 0);
        chk("R10 flush irq kept", 32'(irq_o), 1);
        push(8'h55, 4'h2);
        pop();
        chk("R6 irq low", 32'(irq_o), 0);

        // R10: switch back to single slot with data
        push(8'h01, 0); push(8'h02, 0);
        fe = 0;
        idle();
        chk("R10 back to single", 32'(level_o), 0);
        chk("R10 back empty", 32'(empty_o), 1);
        push(8'h99, 4'h4);
        chk("R4 single full", 32'(full_o), 1);
        step(1, 8'h66, 0, 0, 1, fe, 0, 0);
        chk("R11 single swap", 32'(rd_entry_o), 32'h066);
        idle();
        finish_run();
    end
endmodule